// File: doc/BRIEF.md
# Dual-Mode Dual-Clock Word Buffer

This block is an 18-bit first-in first-out buffer that joins two unrelated clock domains. A producer pushes words on its own clock with an active-low write strobe. A consumer takes them on a second clock with an active-low read strobe. An active-low output enable decides whether the data pins are driven or left floating. Storage depth is a power of two from 512 to 4096 words, set by a parameter.

A strap pin, captured only while the active-low reset is held, selects one of two behaviours. In standard mode the consumer asks for each word and sees it on the pins after the read edge, and the two status pins report "not full" and "not empty". In fall-through mode the oldest word is moved into an output stage without any request, the read strobe retires it, and the two status pins report "cannot accept" and "nothing presented". In both modes three level flags are available: half-full, almost-full and almost-empty, with fixed offsets of 7 words by default.

Top module: `dm_afifo`

## Requirements
- R1: In standard mode, a word on `din` is stored at each rising `wclk` edge where `wen_n` is 0 and the buffer is not full, and words leave in the order they were stored.
- R2: A write attempted while the buffer is full has no effect in either mode; the word never appears at the output.
- R3: In standard mode `wr_flag` is 1 while fewer than DEPTH words are stored and 0 once DEPTH words are stored; it returns to 1 within a few `wclk` cycles after a read frees a slot.
- R4: In standard mode `rd_flag` is 0 when nothing is stored and 1 otherwise; a rising `rclk` edge with `ren_n` at 0 and data stored loads the oldest word onto the output register; a read attempted while empty leaves the output unchanged.
- R5: In fall-through mode the oldest word appears on the output with no read request and `rd_flag` drops to 0 while it is presented; a rising `rclk` edge with `ren_n` at 0 retires it, and `rd_flag` returns to 1 if nothing else is stored.
- R6: In fall-through mode `wr_flag` is 1 when no further word can be accepted and 0 otherwise; the total capacity is DEPTH+1 words (storage plus the output stage).
- R7: While and after reset, `wr_flag` is 1 in standard mode and 0 in fall-through mode, `rd_flag` is 0 in standard mode and 1 in fall-through mode, `half_n` and `afull_n` are 1, `aempty_n` is 0, and the output register is all zeros.
- R8: `half_n` is 0 exactly when the number of stored words exceeds DEPTH/2.
- R9: `afull_n` is 0 exactly when the number of stored words is at least DEPTH minus the almost-full offset (default 7, so 505 of 512).
- R10: `aempty_n` is 0 exactly when the number of stored words is at most the almost-empty offset (default 7).
- R11: When `oe_n` is 1 the `dout` pins are high-impedance; when it is 0 they carry the output register.
- R12: `fwft_sel` is sampled only while `rst_n` is 0 (0 selects standard mode, 1 fall-through mode); changing it afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Producer clock |
| rclk | input | 1 | Consumer clock |
| rst_n | input | 1 | Active-low reset for both domains |
| fwft_sel | input | 1 | Mode strap, captured during reset |
| wen_n | input | 1 | Active-low write strobe |
| din | input | 18 | Write data |
| ren_n | input | 1 | Active-low read strobe |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 18 | Read data, floating when disabled |
| wr_flag | output | 1 | Not-full (standard) or cannot-accept (fall-through) |
| rd_flag | output | 1 | Not-empty (standard) or nothing-presented (fall-through) |
| half_n | output | 1 | Low when more than half full |
| afull_n | output | 1 | Low when almost full |
| aempty_n | output | 1 | Low when almost empty |

## Verification
The hardest point to reach is the fall-through full boundary, where capacity is one word more than the storage because the head word has already moved to the output stage, and the attempted writes past that point must vanish. The bench reaches it by pushing an unbroken stream of words with no reads until the write-side status pin refuses one, counting accepted words, then striking the write strobe again while full before draining everything through the scoreboard. The same fill-without-reads run in standard mode walks the level flags through every threshold word by word.

// File: rtl/dm_afifo_pkg.sv
package dm_afifo_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } fifo_mode_e;
endpackage

// File: rtl/dm_afifo_sync.sv
// Multi-stage synchroniser for a Gray-coded pointer, with conversion
// back to binary in the destination domain.
module dm_afifo_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= gray_in;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   always_comb begin
      logic [W-1:0] acc;
      acc[W-1] = stg[STAGES-1][W-1];
      for (int i = W - 2; i >= 0; i--) acc[i] = acc[i+1] ^ stg[STAGES-1][i];
      bin_out = acc;
   end
endmodule

// File: rtl/dm_afifo_ram.sv
// Two-port storage: clocked write, combinational read.
module dm_afifo_ram #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 9
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dm_afifo_wr.sv
// Producer side: write pointer, full detection and write-domain flags.
module dm_afifo_wr
   import dm_afifo_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int AF_OFF      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rst_n,
   input  logic              mode_strap,
   input  logic              wen_n,
   input  logic [ADDR_W:0]   rd_gray,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W:0]   wr_gray,
   output logic [ADDR_W:0]   fill,
   output fifo_mode_e        mode,
   output logic              wr_flag,
   output logic              half_n,
   output logic              afull_n
);
   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
   localparam logic [PW-1:0] AF_CNT   = PW'(DEPTH - AF_OFF);

   logic [PW-1:0] wbin, wbin_nx, rbin_s;
   logic          full;

   dm_afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk     (wclk),
      .rst_n   (rst_n),
      .gray_in (rd_gray),
      .bin_out (rbin_s)
   );

   // Strap is loaded on every clock while reset is held, then frozen.
   always_ff @(posedge wclk) begin
      if (!rst_n) mode <= fifo_mode_e'(mode_strap);
   end

   assign fill    = wbin - rbin_s;
   assign full    = (fill == FULL_CNT);
   assign we      = !wen_n && !full;
   assign wbin_nx = wbin + PW'(we);
   assign waddr   = wbin[ADDR_W-1:0];

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wr_gray <= '0;
      end else begin
         wbin    <= wbin_nx;
         wr_gray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assign half_n  = !(fill > HALF_CNT);
   assign afull_n = !(fill >= AF_CNT);
   assign wr_flag = (mode == MODE_FWFT) ? full : !full;
endmodule

// File: rtl/dm_afifo_rd.sv
// Consumer side: read pointer, output register / fall-through stage,
// empty detection and the almost-empty flag.
module dm_afifo_rd
   import dm_afifo_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int ADDR_W      = 9,
   parameter int AE_OFF      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              mode_strap,
   input  logic              ren_n,
   input  logic [ADDR_W:0]   wr_gray,
   input  logic [DATA_W-1:0] mem_data,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rd_gray,
   output logic [ADDR_W:0]   fill,
   output fifo_mode_e        mode,
   output logic [DATA_W-1:0] q,
   output logic              rd_flag,
   output logic              aempty_n
);
   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] AE_CNT = PW'(AE_OFF);

   logic [PW-1:0] rbin, rbin_nx, wbin_s;
   logic          mem_empty, pop, valid;

   dm_afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk     (rclk),
      .rst_n   (rst_n),
      .gray_in (wr_gray),
      .bin_out (wbin_s)
   );

   always_ff @(posedge rclk) begin
      if (!rst_n) mode <= fifo_mode_e'(mode_strap);
   end

   assign fill      = wbin_s - rbin;
   assign mem_empty = (fill == '0);
   assign raddr     = rbin[ADDR_W-1:0];

   // Standard: pop on request. Fall-through: refill the stage whenever
   // it is vacant or being retired this cycle.
   always_comb begin
      if (mode == MODE_FWFT) pop = !mem_empty && (!valid || !ren_n);
      else                   pop = !mem_empty && !ren_n;
   end

   assign rbin_nx = rbin + PW'(pop);

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rd_gray <= '0;
         q       <= '0;
         valid   <= 1'b0;
      end else begin
         rbin    <= rbin_nx;
         rd_gray <= rbin_nx ^ (rbin_nx >> 1);
         if (pop) begin
            q     <= mem_data;
            valid <= 1'b1;
         end else if (!ren_n) begin
            valid <= 1'b0;
         end
      end
   end

   assign rd_flag  = (mode == MODE_FWFT) ? !valid : !mem_empty;
   assign aempty_n = !(fill <= AE_CNT);
endmodule

// File: rtl/dm_afifo.sv
module dm_afifo
   import dm_afifo_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int ADDR_W      = 9,
   parameter int AE_OFF      = 7,
   parameter int AF_OFF      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              fwft_sel,
   input  logic              wen_n,
   input  logic [DATA_W-1:0] din,
   input  logic              ren_n,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              wr_flag,
   output logic              rd_flag,
   output logic              half_n,
   output logic              afull_n,
   output logic              aempty_n
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 9 || ADDR_W > 12) begin : g_bad_depth
      $error("dm_afifo: ADDR_W must lie in 9..12");
   end
   if (AE_OFF < 1 || AE_OFF >= DEPTH / 2 || AF_OFF < 1 || AF_OFF >= DEPTH / 2) begin : g_bad_off
      $error("dm_afifo: offsets must lie in 1..DEPTH/2-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dm_afifo: at least two synchroniser stages are required");
   end

   logic              we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [ADDR_W:0]   wr_gray, rd_gray, w_fill, r_fill;
   logic [DATA_W-1:0] mem_data, q_reg;
   fifo_mode_e        w_mode, r_mode;

   dm_afifo_wr #(.ADDR_W(ADDR_W), .AF_OFF(AF_OFF), .SYNC_STAGES(SYNC_STAGES)) u_wr (
      .wclk       (wclk),
      .rst_n      (rst_n),
      .mode_strap (fwft_sel),
      .wen_n      (wen_n),
      .rd_gray    (rd_gray),
      .we         (we),
      .waddr      (waddr),
      .wr_gray    (wr_gray),
      .fill       (w_fill),
      .mode       (w_mode),
      .wr_flag    (wr_flag),
      .half_n     (half_n),
      .afull_n    (afull_n)
   );

   dm_afifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wclk  (wclk),
      .we    (we),
      .waddr (waddr),
      .wdata (din),
      .raddr (raddr),
      .rdata (mem_data)
   );

   dm_afifo_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_OFF(AE_OFF),
                 .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .rclk       (rclk),
      .rst_n      (rst_n),
      .mode_strap (fwft_sel),
      .ren_n      (ren_n),
      .wr_gray    (wr_gray),
      .mem_data   (mem_data),
      .raddr      (raddr),
      .rd_gray    (rd_gray),
      .fill       (r_fill),
      .mode       (r_mode),
      .q          (q_reg),
      .rd_flag    (rd_flag),
      .aempty_n   (aempty_n)
   );

   assign dout = oe_n ? {DATA_W{1'bz}} : q_reg;
endmodule

// File: rtl/dm_afifo_chk.sv
module dm_afifo_chk
   import dm_afifo_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 9
) (
   input logic              wclk,
   input logic              rclk,
   input logic              rst_n,
   input logic              wen_n,
   input logic              rd_flag,
   input logic              half_n,
   input logic              afull_n,
   input logic              aempty_n,
   input logic [ADDR_W:0]   w_fill,
   input logic [ADDR_W:0]   r_fill,
   input fifo_mode_e        r_mode,
   input logic [DATA_W-1:0] q_reg
);
   localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W+1)'(1 << ADDR_W);

   // R2: a write strobe while full never grows the stored count
   p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
      (w_fill == FULL_CNT && !wen_n) |=> (w_fill <= $past(w_fill)));

   // R3: stored count never exceeds the storage depth
   p_fill_bound_r3: assert property (@(posedge wclk) disable iff (!rst_n)
      w_fill <= FULL_CNT);

   // R4: standard mode, nothing stored: output register holds
   p_empty_hold_r4: assert property (@(posedge rclk) disable iff (!rst_n)
      (r_mode == MODE_STD && r_fill == '0) |=> $stable(q_reg));

   // R5: vacant fall-through stage with data stored is loaded next cycle
   p_fwft_load_r5: assert property (@(posedge rclk) disable iff (!rst_n)
      (r_mode == MODE_FWFT && rd_flag && r_fill != '0) |=> !rd_flag);

   // R9: almost-full implies more than half full
   p_af_implies_hf_r9: assert property (@(posedge wclk) disable iff (!rst_n)
      !afull_n |-> !half_n);

   // R10: standard-mode empty implies almost-empty
   p_empty_implies_ae_r10: assert property (@(posedge rclk) disable iff (!rst_n)
      (r_mode == MODE_STD && !rd_flag) |-> !aempty_n);
endmodule

bind dm_afifo dm_afifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .wclk     (wclk),
   .rclk     (rclk),
   .rst_n    (rst_n),
   .wen_n    (wen_n),
   .rd_flag  (rd_flag),
   .half_n   (half_n),
   .afull_n  (afull_n),
   .aempty_n (aempty_n),
   .w_fill   (w_fill),
   .r_fill   (r_fill),
   .r_mode   (r_mode),
   .q_reg    (q_reg)
);

// File: tb/dm_afifo_bench.sv
`timescale 1ns/1ps
module dm_afifo_bench;
   localparam int DW = 18, AW = 9, DEPTH = 1 << AW, AE = 7, AF = 7;

   logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, fwft_sel = 1'b0;
   logic wen_n = 1'b1, ren_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   tri1  [DW-1:0] dout;
   logic wr_flag, rd_flag, half_n, afull_n, aempty_n;

   int n_cmp = 0, n_bad = 0;
   bit cur_fwft = 1'b0;
   logic [DW-1:0] sbq [$];

   always #4   wclk = ~wclk;
   always #5.5 rclk = ~rclk;

   dm_afifo u_dm_afifo (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
      .wen_n(wen_n), .din(din), .ren_n(ren_n), .oe_n(oe_n), .dout(dout),
      .wr_flag(wr_flag), .rd_flag(rd_flag), .half_n(half_n),
      .afull_n(afull_n), .aempty_n(aempty_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Reset with the strap at `m`, then flip the strap (R12).
   task automatic do_reset(input bit m);
      rst_n = 1'b0; fwft_sel = m; wen_n = 1'b1; ren_n = 1'b1; cur_fwft = m;
      sbq.delete();
      repeat (4) @(negedge wclk);
      repeat (4) @(negedge rclk);
      rst_n = 1'b1;
      fwft_sel = ~m;
      repeat (3) @(negedge rclk);
   endtask

   // Driver: one write attempt; pushes the expected word when accepted.
   task automatic push_word(input logic [DW-1:0] d, output bit took);
      @(negedge wclk);
      took = cur_fwft ? (wr_flag == 1'b0) : (wr_flag == 1'b1);
      wen_n = 1'b0; din = d;
      @(negedge wclk);
      wen_n = 1'b1;
      if (took) sbq.push_back(d);
   endtask

   // Monitor, standard mode: request, then compare the loaded word.
   task automatic pop_std(output bit got);
      logic [DW-1:0] e;
      @(negedge rclk);
      got = rd_flag;
      ren_n = 1'b0;
      @(negedge rclk);
      ren_n = 1'b1;
      if (got) begin
         e = sbq.pop_front();
         check("R1 R4 read data", dout, e);
      end
   endtask

   // Monitor, fall-through mode: compare the presented word, then retire.
   task automatic pop_fwft(output bit got);
      logic [DW-1:0] e;
      @(negedge rclk);
      got = !rd_flag;
      if (got) begin
         e = sbq.pop_front();
         check("R5 presented word", dout, e);
         ren_n = 1'b0;
         @(negedge rclk);
         ren_n = 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge wclk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      bit ok;
      logic [DW-1:0] held;
      int acc;

      // ---------------- standard mode ----------------
      do_reset(1'b0);
      check("R7 std wr_flag", wr_flag, 1);
      check("R7 std rd_flag", rd_flag, 0);
      check("R7 half_n", half_n, 1);
      check("R7 afull_n", afull_n, 1);
      check("R7 aempty_n", aempty_n, 0);
      check("R7 output zero", dout, 0);
      oe_n = 1'b1; #1;
      check("R11 outputs float", dout, 18'h3FFFF);
      oe_n = 1'b0; #1;
      check("R11 outputs driven", dout, 0);

      for (int k = 0; k < 3; k++) push_word(18'h10 + 18'(k), ok);
      repeat (6) @(negedge rclk);
      check("R12 R4 strap ignored, not-empty", rd_flag, 1);
      check("R10 three words", aempty_n, 0);
      check("R4 no auto-present", dout, 0);
      for (int k = 0; k < 3; k++) pop_std(ok);
      check("R4 empty after drain", rd_flag, 0);
      held = dout;
      pop_std(ok);
      check("R4 empty read no pop", ok, 0);
      check("R4 empty read holds output", dout, held);

      // fill with no reads, walking every threshold
      for (int k = 1; k <= DEPTH; k++) begin
         push_word(18'(k * 37 + 5), ok);
         if (!ok) check("R1 write accepted", ok, 1);
         if (k == AE || k == AE + 1) begin
            repeat (6) @(negedge rclk);
            check("R10 aempty_n threshold", aempty_n, (k == AE) ? 0 : 1);
         end
         if (k == DEPTH / 2)      check("R8 half_n at half", half_n, 1);
         if (k == DEPTH / 2 + 1)  check("R8 half_n above half", half_n, 0);
         if (k == DEPTH - AF - 1) check("R9 afull_n below", afull_n, 1);
         if (k == DEPTH - AF)     check("R9 afull_n at offset", afull_n, 0);
         if (k == DEPTH - 1)      check("R3 one slot left", wr_flag, 1);
      end
      check("R3 full", wr_flag, 0);
      for (int k = 0; k < 3; k++) begin
         push_word(18'h3DEAD, ok);
         check("R2 write refused when full", ok, 0);
      end

      pop_std(ok);
      repeat (6) @(negedge wclk);
      check("R3 not full after read", wr_flag, 1);
      acc = 0;
      while (sbq.size() > 0 && acc < 4 * DEPTH) begin
         pop_std(ok);
         acc++;
      end
      check("R1 all stored words read", sbq.size(), 0);
      repeat (6) @(negedge rclk);
      check("R2 nothing extra stored", rd_flag, 0);

      // ---------------- fall-through mode ----------------
      do_reset(1'b1);
      check("R7 fwft wr_flag", wr_flag, 0);
      check("R7 fwft rd_flag", rd_flag, 1);
      check("R7 fwft half_n", half_n, 1);
      check("R7 fwft aempty_n", aempty_n, 0);
      check("R7 fwft output zero", dout, 0);

      push_word(18'h2AAAA, ok);
      repeat (6) @(negedge rclk);
      check("R12 R5 presented without request", rd_flag, 0);
      check("R5 head word on outputs", dout, 18'h2AAAA);
      pop_fwft(ok);
      repeat (2) @(negedge rclk);
      check("R5 nothing presented after retire", rd_flag, 1);

      acc = 0;
      ok = 1'b1;
      while (ok && acc < DEPTH + 8) begin
         push_word(18'(acc * 11 + 3), ok);
         if (ok) acc++;
      end
      check("R6 capacity DEPTH+1", acc, DEPTH + 1);
      check("R6 cannot accept", wr_flag, 1);
      push_word(18'h1BEEF, ok);
      check("R2 fwft write refused when full", ok, 0);

      pop_fwft(ok);
      repeat (6) @(negedge wclk);
      check("R6 accepts after retire", wr_flag, 0);
      acc = 0;
      while (sbq.size() > 0 && acc < 8 * DEPTH) begin
         pop_fwft(ok);
         acc++;
      end
      check("R5 all words presented", sbq.size(), 0);
      repeat (6) @(negedge rclk);
      check("R2 fwft nothing extra stored", rd_flag, 1);

      summary();
   end
endmodule